// File: doc/BRIEF.md
# Repetitive Control Correction Path

This block is a fixed-point plug-in repetitive controller meant to sit in cascade with an inner current regulator. On every sample strobe it takes the signed tracking error and adds to it a low-pass filtered copy of what it stored one grid period earlier. The sum goes back into a circular buffer, and the filtered feedback, scaled by a gain, leaves the block as a correction term. The surrounding loop adds that term to the inner regulator's reference.

Sampling is assumed to be phase-locked to the grid, so one grid period always spans exactly `N` samples (200 by default). The delay therefore has a fixed integer length and has no fractional interpolation. The filter weights never change. A small read advance of 0 to 7 samples stands in for the phase-lead filter. A three-tap symmetric smoother with weights one quarter, one half and one quarter stands in for the low-pass filter. Dropping the enable wipes the stored period and forces the correction to zero.

Top module: `rc_plugin_ctrl`

## Requirements
- R1: After synchronous active-low reset the correction output is 0 and the stored period is all zeros, so a strobe in the first period yields correction 0.
- R2: The correction for a strobe is on `corr` two clock edges after the edge that samples the strobe. It is not yet changed one edge after, and it holds steady between strobes even if `gain` changes.
- R3: The value written for sample n is v[n] = err[n] + f[n], saturated to the signed DW range (-32768..32767 by default). It never wraps.
- R4: The feedback is f[n] = floor((v[n-d-1] + 2*v[n-d] + v[n-d+1]) / 4), with d = N - adv. Samples before the last enable or reset count as 0.
- R5: `adv` (0..7) moves the centre tap of the feedback k samples earlier, so an impulse peak is echoed d = N - k samples after it was applied.
- R6: The correction is floor(gain * f[n] / 64), saturated to the signed OW range. `gain` is unsigned, with 64 meaning unity, and a gain of 0 gives 0.
- R7: While `en` is low, `corr` is 0 from the next edge on. Strobes are ignored and the stored period is cleared, so after re-enable no earlier sample echoes.
- R8: With adv = 0 and unity gain, an impulse of amplitude A returns exactly N samples later as floor(A/2), with floor(A/4) on each neighbouring sample. The full period loses no gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Controller enable. Low clears the stored period and the output |
| stb | input | 1 | One-clock sample strobe |
| err | input | DW | Signed tracking error for this sample |
| adv | input | AW | Read advance k, in samples |
| gain | input | GW | Unsigned correction gain, with GF fraction bits |
| corr | output | OW | Signed saturated correction |

## Verification
Every correction appears two rising edges after the edge that samples its strobe. The bench raises the strobe on a falling edge and reads `corr` on the falling edge after the second rising edge. In the latency test it also reads `corr` after the first rising edge to confirm the old value is still there. The clear caused by a low enable shows up one edge later, so that check reads `corr` at the next falling edge. Every other expected value comes from a sample-indexed model of R3, R4 and R6 kept in the bench, or from hand-computed impulse echoes in the vector table.

// File: rtl/rc_pkg.sv
// Shared helpers for the repetitive-control path.
// Assumes all intermediate arithmetic fits in a signed 64-bit value.
package rc_pkg;

    // Clamp a value into the signed range of a w-bit word.
    function automatic longint clamp_to(input longint x, input int w);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -(longint'(1) <<< (w - 1));
        if (x > hi)
            return hi;
        else if (x < lo)
            return lo;
        else
            return x;
    endfunction

endpackage

// File: rtl/rc_delay_line.sv
// Circular store of one grid period plus one slot (N+1 words).
// Gives three taps at lags N-k+1, N-k and N-k-1 behind the sample now
// being written, where k = adv. Assumes N >= 2^AW + 2, so every lag is at
// least 1 and at most N+1. Cleared whenever rst_n or en is low.
module rc_delay_line #(
    parameter int DW = 16,
    parameter int N  = 200,
    parameter int AW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 stb,
    input  logic [AW-1:0]        adv,
    input  logic signed [DW-1:0] wdata,
    output logic signed [DW-1:0] tap_old,
    output logic signed [DW-1:0] tap_mid,
    output logic signed [DW-1:0] tap_new
);
    localparam int DEPTH = N + 1;
    localparam int PW    = $clog2(DEPTH);

    logic signed [DW-1:0] mem [DEPTH];
    logic [PW-1:0]        wp;
    logic signed [DW-1:0] rd [3];

    // Read the three feedback taps relative to the write pointer.
    for (genvar t = 0; t < 3; t++) begin : g_tap
        always_comb begin
            int lag;
            int idx;
            lag = N + 1 - t - int'(adv);
            idx = int'(wp) + DEPTH - lag;
            if (idx >= DEPTH)
                idx = idx - DEPTH;
            rd[t] = mem[idx[PW-1:0]];
        end
    end

    assign tap_old = rd[0];
    assign tap_mid = rd[1];
    assign tap_new = rd[2];

    // Store the new sample and advance the pointer, or wipe the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
            wp <= '0;
        end else if (stb) begin
            mem[wp] <= wdata;
            wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        end
    end

    p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wp) < DEPTH);

    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stb) |=> (int'(wp) == ((int'($past(wp)) == DEPTH - 1) ? 0 : int'($past(wp)) + 1)));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (wp == '0));

endmodule

// File: rtl/rc_qfilter.sv
// Three-tap symmetric smoother (1/4, 1/2, 1/4) on the stored taps.
// The result is floored and never leaves the span of its taps, so it
// fits DW bits. Also holds one registered copy of the result per strobe
// and flags it for the gain stage.
module rc_qfilter #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 stb,
    input  logic signed [DW-1:0] tap_old,
    input  logic signed [DW-1:0] tap_mid,
    input  logic signed [DW-1:0] tap_new,
    output logic signed [DW-1:0] f_now,
    output logic signed [DW-1:0] f_q,
    output logic                 fire
);
    localparam int SW = DW + 2;

    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] avg;

    // Weighted sum and floor divide by four.
    always_comb begin
        sum   = SW'(tap_old) + (SW'(tap_mid) <<< 1) + SW'(tap_new);
        avg   = sum >>> 2;
        f_now = avg[DW-1:0];
    end

    // Capture the feedback once per strobe and mark it for the next stage.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            f_q  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= stb;
            if (stb)
                f_q <= f_now;
        end
    end

    p_fb_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((tap_old <= f_now) || (tap_mid <= f_now) || (tap_new <= f_now)) &&
        ((tap_old >= f_now) || (tap_mid >= f_now) || (tap_new >= f_now)));

endmodule

// File: rtl/rc_gain_sat.sv
// Output stage: scales the registered feedback by an unsigned gain with
// GF fraction bits, floors, saturates to OW bits and holds the result
// until the next fire pulse. Forced to zero while disabled.
module rc_gain_sat #(
    parameter int DW = 16,
    parameter int GW = 8,
    parameter int GF = 6,
    parameter int OW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 fire,
    input  logic signed [DW-1:0] f_q,
    input  logic [GW-1:0]        gain,
    output logic signed [OW-1:0] corr
);
    longint               scaled;
    logic signed [63:0]   limited;

    // Scale, floor and clamp the feedback.
    always_comb begin
        scaled  = (longint'(f_q) * longint'(gain)) >>> GF;
        limited = rc_pkg::clamp_to(scaled, OW);
    end

    // Update the correction only when a new feedback value arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            corr <= '0;
        else if (fire)
            corr <= limited[OW-1:0];
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !fire) |=> $stable(corr));

    p_zero_gain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fire && (gain == '0)) |=> (corr == '0));

endmodule

// File: rtl/rc_plugin_ctrl.sv
// Plug-in repetitive controller. Per strobe it sums the error with the
// smoothed value from one period back, writes that sum into the delay
// line, and drives gain times the smoothed value as correction two
// edges later. Assumes the strobe rate is locked to N samples per grid
// period and strobes are at least two clocks apart.
module rc_plugin_ctrl #(
    parameter int DW = 16,
    parameter int N  = 200,
    parameter int AW = 3,
    parameter int GW = 8,
    parameter int GF = 6,
    parameter int OW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 stb,
    input  logic signed [DW-1:0] err,
    input  logic [AW-1:0]        adv,
    input  logic [GW-1:0]        gain,
    output logic signed [OW-1:0] corr
);
    logic signed [DW-1:0] tap_old;
    logic signed [DW-1:0] tap_mid;
    logic signed [DW-1:0] tap_new;
    logic signed [DW-1:0] f_now;
    logic signed [DW-1:0] f_q;
    logic                 fire;
    logic signed [DW-1:0] wdata;
    logic signed [63:0]   wsum;

    // Saturating sum of the error and the feedback, to be stored.
    always_comb begin
        wsum  = rc_pkg::clamp_to(longint'(err) + longint'(f_now), DW);
        wdata = wsum[DW-1:0];
    end

    rc_delay_line #(.DW(DW), .N(N), .AW(AW)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .stb     (stb),
        .adv     (adv),
        .wdata   (wdata),
        .tap_old (tap_old),
        .tap_mid (tap_mid),
        .tap_new (tap_new)
    );

    rc_qfilter #(.DW(DW)) u_qf (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .stb     (stb),
        .tap_old (tap_old),
        .tap_mid (tap_mid),
        .tap_new (tap_new),
        .f_now   (f_now),
        .f_q     (f_q),
        .fire    (fire)
    );

    rc_gain_sat #(.DW(DW), .GW(GW), .GF(GF), .OW(OW)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .fire  (fire),
        .f_q   (f_q),
        .gain  (gain),
        .corr  (corr)
    );

    p_nowrap_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((err > 0) && (f_now > 0)) |-> (wdata > 0));

    p_nowrap_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((err < 0) && (f_now < 0)) |-> (wdata < 0));

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (corr == '0));

endmodule

// File: tb/rc_plugin_ctrl_tb.sv
`timescale 1ns/1ps
module rc_plugin_ctrl_tb;
    localparam int N = 200;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en = 1'b0;
    logic               stb = 1'b0;
    logic signed [15:0] err = '0;
    logic [2:0]         adv = '0;
    logic [7:0]         gain = 8'd64;
    logic signed [15:0] corr;

    int errors = 0;
    int checks = 0;
    int hist [0:1023];
    int ns = 0;
    int exp_y = 0;
    int mid_y = 0;
    int cycles = 0;

    // adv, gain, impulse amplitude, sample to check, expected correction
    localparam int TV [10][5] = '{
        '{0,  64,    400, 200,    200},
        '{0,  64,    400, 199,    100},
        '{0,  64,    400, 201,    100},
        '{3,  64,    400, 197,    200},
        '{7, 128,    400, 193,    400},
        '{0,  32,   -401, 200,   -101},
        '{0, 255,  30000, 200,  32767},
        '{0, 255, -30000, 200, -32768},
        '{5,  64,    400, 194,    100},
        '{0,  64,    400, 198,      0}
    };

    rc_plugin_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .stb(stb),
        .err(err), .adv(adv), .gain(gain), .corr(corr)
    );

    always #4 clk = ~clk;

    function automatic int clampi(input int x, input int w);
        int hi;
        int lo;
        hi = (1 <<< (w - 1)) - 1;
        lo = -(1 <<< (w - 1));
        return (x > hi) ? hi : ((x < lo) ? lo : x);
    endfunction

    function automatic int hv(input int i);
        return (i < 0) ? 0 : hist[i];
    endfunction

    task automatic check(input int got, input int expv, input string tag);
        checks++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One sample: model it, strobe it, read corr after the second edge.
    task automatic step(input int e);
        int d;
        int f;
        d = N - int'(adv);
        f = (hv(ns - d - 1) + 2 * hv(ns - d) + hv(ns - d + 1)) >>> 2;
        hist[ns] = clampi(e + f, 16);
        ns++;
        exp_y = clampi((int'(gain) * f) >>> 6, 16);
        @(negedge clk);
        stb = 1'b1;
        err = 16'(e);
        @(negedge clk);
        stb = 1'b0;
        mid_y = int'(corr);
        @(negedge clk);
    endtask

    task automatic wipe();
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        ns = 0;
        for (int i = 0; i < 1024; i++) hist[i] = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: got %0d cycles expected under 200000", cycles);
                summary();
            end
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) hist[i] = 0;
        en = 1'b1;
        stb = 1'b1;
        err = 16'sd1234;
        repeat (3) @(negedge clk);
        stb = 1'b0;
        check(int'(corr), 0, "R1 reset output");
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(corr), 0, "R1 output after reset release");
        step(1000);
        check(int'(corr), 0, "R1 empty period first strobe");

        // Table of impulse echoes: R4 R5 R6 R8.
        for (int t = 0; t < 10; t++) begin
            wipe();
            adv  = 3'(TV[t][0]);
            gain = 8'(TV[t][1]);
            for (int s = 0; s <= TV[t][3]; s++)
                step((s == 0) ? TV[t][2] : 0);
            check(int'(corr), TV[t][4], $sformatf("R4/R5/R6/R8 table row %0d", t));
            check(int'(corr), exp_y, $sformatf("R4 model row %0d", t));
        end

        // Latency and hold: R2.
        wipe();
        adv = 3'd0;
        gain = 8'd64;
        for (int s = 0; s < N; s++) step((s == 0) ? 400 : 0);
        check(int'(corr), 100, "R8 neighbour before peak");
        step(0);
        check(mid_y, 100, "R2 not yet updated one edge after strobe");
        check(int'(corr), 200, "R2 updated two edges after strobe");
        gain = 8'd128;
        repeat (5) @(negedge clk);
        check(int'(corr), 200, "R2 holds between strobes on gain change");

        // Disable clears: R7.
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(int'(corr), 0, "R7 output zero one edge after disable");
        stb = 1'b1;
        err = 16'sd5000;
        @(negedge clk);
        stb = 1'b0;
        repeat (2) @(negedge clk);
        check(int'(corr), 0, "R7 strobe ignored while disabled");
        en = 1'b1;
        gain = 8'd64;
        ns = 0;
        for (int i = 0; i < 1024; i++) hist[i] = 0;
        for (int s = 0; s <= N; s++) step(0);
        check(int'(corr), 0, "R7 no echo after re-enable");

        // Saturating accumulation of a DC error: R3.
        wipe();
        adv = 3'd0;
        gain = 8'd64;
        for (int s = 0; s < 3 * N; s++) begin
            step(20000);
            if (s % 50 == 0)
                check(int'(corr), exp_y, $sformatf("R3 model sample %0d", s));
            if (s == 2 * N + 100)
                check(int'(corr), 32767, "R3 stored value saturates");
        end

        summary();
    end
endmodule